// File: doc/BRIEF.md
# Working-Zone Address Bus Decoder

This block sits at the receiving end of a low-activity encoded address bus and rebuilds each original address. The sender sends either a full address (a zone miss) or a small signed step from the last address seen in one of a few tracked working zones. It signals the step by flipping a single bit of the data word relative to the previous word, or by flipping no bit at all, which means "repeat this zone's previous step". The decoder keeps its own copy of every zone base, every zone's last step, the previous received word and the least-recently-used order. These copies follow the same update rules as the sender, so both sides stay in step without any side channel.

Each transfer has a strobe, a word of `ADDR_W` bits, a zone index and a miss bit. One clock later the rebuilt address appears with an output strobe. A flag marks hit transfers whose word differs from the previous word in more than one bit. The bus cannot produce such a word legally, so the flag points to a sender/receiver mismatch.

Top module: `wz_addr_decoder`

## Requirements
- R1: On a strobed transfer with miss = 1, the output address equals the received word.
- R2: A miss writes the received word into the base of the least-recently-used zone, ignores the zone index input, and leaves every zone's stored step unchanged.
- R3: On a hit whose word differs from the previous word, the step is taken from the lowest differing bit position p as p - ADDR_W/2. The output is the selected zone's base plus that step, and the step becomes that zone's stored step.
- R4: On a hit whose word equals the previous word, the output is the selected zone's base plus its stored step, and the stored step is not changed.
- R5: After every hit, the selected zone's base holds the output address.
- R6: Every strobed transfer, hit or miss, makes its word the previous word for the next transfer.
- R7: After reset all bases, steps and the previous word are zero. The recency order is zone 0 newest up to zone ZONES-1 oldest. Every transfer makes the zone it used the newest, and a miss fills the oldest zone.
- R8: The error flag is 1 exactly for a hit whose word differs from the previous word in two or more bits. That transfer is still decoded from the lowest differing bit. The flag is 0 on misses.
- R9: The output strobe is 1 exactly one clock after a strobed input. Without a strobe, no state changes and the output address holds.
- R10: Bit 0 decodes to step -ADDR_W/2, bit ADDR_W-1 to step ADDR_W/2-1, and address sums wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_vld_i | input | 1 | Transfer strobe |
| word_i | input | ADDR_W | Encoded data word |
| zone_i | input | $clog2(ZONES) | Zone index of a hit |
| miss_i | input | 1 | 1 = word is a full address |
| addr_o | output | ADDR_W | Rebuilt address |
| addr_vld_o | output | 1 | Output strobe |
| err_o | output | 1 | Multi-bit difference on a hit |

## Verification
The bench plays the sender: it encodes thousands of addresses drawn from more walking streams than there are zones. This forces steady evictions, and every output must match the original address. A decoder that refreshed the previous word only on hits, evicted the wrong zone, or overwrote the stored step on a repeat would drift out of step and return wrong addresses soon after. Directed transfers target the two extreme bit positions and a sum that crosses the top of the address space, where an off-by-one step mapping or a missing wrap shows up at once. They also cover a multi-bit word that must raise the flag while still decoding from its lowest bit, and idle cycles during which the output must hold.

// File: rtl/wz_pkg.sv
package wz_pkg;

    // Decoding action chosen for one cycle
    typedef enum logic [1:0] {
        XK_IDLE   = 2'd0,
        XK_MISS   = 2'd1,
        XK_REPEAT = 2'd2,
        XK_STEP   = 2'd3
    } xfer_kind_e;

endpackage

// File: rtl/wz_bit_locate.sv
module wz_bit_locate #(
    parameter  int W     = 16,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o,
    output logic             multi_o
);

    // Lowest set bit wins; scanning downward leaves the lowest one last
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o   = |vec_i;
    assign multi_o = |(vec_i & (vec_i - W'(1)));

    // A single-bit vector must be reproduced exactly by its index (R3)
    always_comb begin
        if (any_o && !multi_o) begin
            p_single_bit_index_r3: assert (vec_i == (W'(1) << idx_o));
        end
    end

endmodule

// File: rtl/wz_lru.sv
module wz_lru #(
    parameter  int ZONES = 4,
    localparam int ID_W  = $clog2(ZONES)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            touch_i,
    input  logic [ID_W-1:0] touch_idx_i,
    output logic [ID_W-1:0] victim_o
);

    localparam logic [ID_W-1:0] OLDEST = ID_W'(ZONES - 1);

    typedef struct packed {
        logic [ZONES-1:0][ID_W-1:0] age;
    } lru_t;

    lru_t lru_d, lru_q;
    logic [ZONES-1:0] oldest_vec;

    always_comb begin
        lru_d = lru_q;
        if (touch_i) begin
            for (int j = 0; j < ZONES; j++) begin
                if (ID_W'(j) == touch_idx_i)
                    lru_d.age[j] = '0;
                else if (lru_q.age[j] < lru_q.age[touch_idx_i])
                    lru_d.age[j] = lru_q.age[j] + ID_W'(1);
            end
        end
    end

    generate
        for (genvar g = 0; g < ZONES; g++) begin : g_oldest
            assign oldest_vec[g] = (lru_q.age[g] == OLDEST);
        end
    endgenerate

    always_comb begin
        victim_o = '0;
        for (int j = 0; j < ZONES; j++) begin
            if (oldest_vec[j]) victim_o = ID_W'(j);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int j = 0; j < ZONES; j++) lru_q.age[j] <= ID_W'(j);
        end else begin
            lru_q <= lru_d;
        end
    end

    p_one_oldest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(oldest_vec) == 1);

    p_touch_newest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        touch_i |=> lru_q.age[$past(touch_idx_i)] == '0);

endmodule

// File: rtl/wz_zone_bank.sv
module wz_zone_bank #(
    parameter  int ADDR_W = 16,
    parameter  int ZONES  = 4,
    localparam int ID_W   = $clog2(ZONES),
    localparam int OFS_W  = $clog2(ADDR_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ID_W-1:0]   rd_idx_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [OFS_W-1:0]  ofs_o,
    input  logic [ID_W-1:0]   wr_idx_i,
    input  logic              base_we_i,
    input  logic [ADDR_W-1:0] base_wd_i,
    input  logic              ofs_we_i,
    input  logic [OFS_W-1:0]  ofs_wd_i
);

    typedef struct packed {
        logic [ZONES-1:0][ADDR_W-1:0] base;
        logic [ZONES-1:0][OFS_W-1:0]  ofs;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (base_we_i) bank_d.base[wr_idx_i] = base_wd_i;
        if (ofs_we_i)  bank_d.ofs[wr_idx_i]  = ofs_wd_i;
    end

    assign base_o = bank_q.base[rd_idx_i];
    assign ofs_o  = bank_q.ofs[rd_idx_i];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) bank_q <= '0;
        else         bank_q <= bank_d;
    end

    p_base_written_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        base_we_i |=> bank_q.base[$past(wr_idx_i)] == $past(base_wd_i));

    p_step_written_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ofs_we_i |=> bank_q.ofs[$past(wr_idx_i)] == $past(ofs_wd_i));

    p_step_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ofs_we_i |=> $stable(bank_q.ofs));

endmodule

// File: rtl/wz_addr_decoder.sv
module wz_addr_decoder #(
    parameter  int ADDR_W = 16,
    parameter  int ZONES  = 4,
    localparam int ID_W   = $clog2(ZONES),
    localparam int OFS_W  = $clog2(ADDR_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_vld_i,
    input  logic [ADDR_W-1:0] word_i,
    input  logic [ID_W-1:0]   zone_i,
    input  logic              miss_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_vld_o,
    output logic              err_o
);

    import wz_pkg::*;

    localparam logic [OFS_W-1:0] HALF = OFS_W'(ADDR_W / 2);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              vld;
        logic              err;
        logic [ADDR_W-1:0] prev_word;
    } state_t;

    state_t st_d, st_q;

    xfer_kind_e        kind;
    logic [ADDR_W-1:0] diff;
    logic [OFS_W-1:0]  bit_idx;
    logic              diff_any, diff_multi;
    logic [ID_W-1:0]   victim, tgt;
    logic [ADDR_W-1:0] base_rd, sum, addr_new;
    logic [OFS_W-1:0]  ofs_rd, ofs_step, ofs_used;

    assign diff = word_i ^ st_q.prev_word;

    wz_bit_locate #(.W(ADDR_W)) u_locate (
        .vec_i   (diff),
        .idx_o   (bit_idx),
        .any_o   (diff_any),
        .multi_o (diff_multi)
    );

    wz_lru #(.ZONES(ZONES)) u_lru (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .touch_i     (in_vld_i),
        .touch_idx_i (tgt),
        .victim_o    (victim)
    );

    wz_zone_bank #(.ADDR_W(ADDR_W), .ZONES(ZONES)) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_idx_i  (zone_i),
        .base_o    (base_rd),
        .ofs_o     (ofs_rd),
        .wr_idx_i  (tgt),
        .base_we_i (in_vld_i),
        .base_wd_i (addr_new),
        .ofs_we_i  (kind == XK_STEP),
        .ofs_wd_i  (ofs_step)
    );

    always_comb begin
        if (!in_vld_i)     kind = XK_IDLE;
        else if (miss_i)   kind = XK_MISS;
        else if (!diff_any) kind = XK_REPEAT;
        else               kind = XK_STEP;
    end

    // Bit position p maps to step p - ADDR_W/2 (modulo 2^OFS_W)
    assign ofs_step = bit_idx - HALF;
    assign ofs_used = (kind == XK_STEP) ? ofs_step : ofs_rd;
    assign sum      = base_rd + {{(ADDR_W - OFS_W){ofs_used[OFS_W-1]}}, ofs_used};
    assign addr_new = (kind == XK_MISS) ? word_i : sum;
    assign tgt      = miss_i ? victim : zone_i;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld_i;
        st_d.err = (kind == XK_STEP) && diff_multi;
        if (in_vld_i) begin
            st_d.addr      = addr_new;
            st_d.prev_word = word_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign addr_o     = st_q.addr;
    assign addr_vld_o = st_q.vld;
    assign err_o      = st_q.err;

    p_out_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_vld_i |=> addr_vld_o);

    p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_vld_i |=> (!addr_vld_o && $stable(addr_o)));

    p_miss_word_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_vld_i && miss_i) |=> addr_o == $past(word_i));

    p_no_err_on_miss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_vld_i && miss_i) |=> !err_o);

    p_err_with_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> addr_vld_o);

endmodule

// File: tb/wz_addr_decoder_bench.sv
`timescale 1ns/1ps
module wz_addr_decoder_bench;

    localparam int AW = 16;
    localparam int NZ = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [AW-1:0] word = '0;
    logic [1:0]    zone = '0;
    logic          miss = 1'b0;
    logic [AW-1:0] addr;
    logic          addr_vld, err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    wz_addr_decoder #(.ADDR_W(AW), .ZONES(NZ)) u_wz_addr_decoder (
        .clk_i(clk), .rst_ni(rst_n), .in_vld_i(in_vld), .word_i(word),
        .zone_i(zone), .miss_i(miss), .addr_o(addr), .addr_vld_o(addr_vld),
        .err_o(err)
    );

    // Reference state, built from the requirements
    logic [AW-1:0] m_base [NZ];
    logic [3:0]    m_ofs  [NZ];
    int            m_age  [NZ];
    logic [AW-1:0] m_prev;

    task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic touch(input int t);
        for (int j = 0; j < NZ; j++)
            if (j != t && m_age[j] < m_age[t]) m_age[j]++;
        m_age[t] = 0;
    endtask

    task automatic xfer(input logic [AW-1:0] w, input logic [1:0] z, input logic ms,
                        input logic [AW-1:0] exp_a, input logic exp_e, input string tag);
        @(negedge clk);
        in_vld = 1'b1; word = w; zone = z; miss = ms;
        @(negedge clk);
        in_vld = 1'b0; word = $urandom; zone = 2'($urandom); miss = 1'($urandom);
        check({tag, " strobe R9"}, {15'd0, addr_vld}, 16'd1);
        check({tag, " addr"}, addr, exp_a);
        check({tag, " err R8"}, {15'd0, err}, {15'd0, exp_e});
    endtask

    task automatic do_miss(input logic [AW-1:0] a, input string tag);
        int v;
        v = 0;
        for (int j = 0; j < NZ; j++) if (m_age[j] == NZ - 1) v = j;
        xfer(a, 2'($urandom), 1'b1, a, 1'b0, tag);   // zone index ignored (R2)
        m_base[v] = a;
        touch(v);
        m_prev = a;
    endtask

    task automatic do_hit(input int z, input logic [AW-1:0] w, input string tag);
        logic [AW-1:0] x, e;
        logic [3:0]    o, p;
        logic          multi;
        x = w ^ m_prev;
        multi = (x & (x - 16'd1)) != 0;
        if (x == 0) begin
            o = m_ofs[z];
        end else begin
            p = 0;
            for (int i = AW - 1; i >= 0; i--) if (x[i]) p = 4'(i);
            o = p - 4'd8;
            m_ofs[z] = o;
        end
        e = m_base[z] + {{12{o[3]}}, o};
        xfer(w, 2'(z), 1'b0, e, multi, tag);
        m_base[z] = e;
        touch(z);
        m_prev = w;
    endtask

    // Sender side of the bus: encode an address and push it through
    task automatic enc_send(input logic [AW-1:0] a, input string tag);
        logic [AW-1:0] d;
        int hz;
        hz = -1;
        for (int k = NZ - 1; k >= 0; k--) begin
            d = a - m_base[k];
            if (d <= 16'd7 || d >= 16'hFFF8) hz = k;
        end
        if (hz < 0) begin
            do_miss(a, tag);
        end else begin
            d = a - m_base[hz];
            if (d[3:0] == m_ofs[hz]) do_hit(hz, m_prev, tag);
            else do_hit(hz, m_prev ^ (16'd1 << (d[3:0] ^ 4'h8)), tag);
        end
    endtask

    task automatic finish_run;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [AW-1:0] held;
        logic [AW-1:0] stream [6];
        for (int j = 0; j < NZ; j++) begin
            m_base[j] = '0; m_ofs[j] = '0; m_age[j] = j;
        end
        m_prev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state
        check("reset strobe R7", {15'd0, addr_vld}, 16'd0);
        check("reset err R7", {15'd0, err}, 16'd0);
        check("reset addr R7", addr, 16'd0);

        // R4: zero difference repeats the reset step of zero
        do_hit(0, 16'h0000, "repeat zero R4");
        // R1 R2: miss fills oldest zone (zone 3)
        do_miss(16'h4000, "miss R1");
        // R3 R6: step relative to the miss word, zone 3 must hold 0x4000 (R2 R7)
        do_hit(3, 16'h4000 ^ (16'd1 << 11), "step +3 R3");
        // R4: repeat the +3 step, stored step kept
        do_hit(3, m_prev, "repeat +3 R4");
        // R5: base followed the outputs
        do_hit(3, m_prev ^ 16'h0100, "step 0 after repeats R5");
        // R10: extreme positions
        do_hit(3, m_prev ^ 16'h0001, "bit0 -8 R10");
        do_hit(3, m_prev ^ 16'h8000, "bit15 +7 R10");
        // R10: wrap across top of space; zone 2 is oldest now
        do_miss(16'hFFFE, "miss high R2");
        do_hit(2, m_prev ^ 16'h8000, "wrap R10");
        // R8: two differing bits, decoded from lowest
        do_hit(1, m_prev ^ 16'h0110, "multi-bit R8");

        // R9: idle cycle holds output
        held = addr;
        @(negedge clk);
        check("idle strobe R9", {15'd0, addr_vld}, 16'd0);
        check("idle hold R9", addr, held);

        // Sweep: more streams than zones, walking with small strides
        for (int s = 0; s < 6; s++) stream[s] = 16'($urandom);
        for (int n = 0; n < 3000; n++) begin
            int s;
            logic [AW-1:0] a;
            s = $urandom_range(0, 5);
            if ($urandom_range(0, 9) == 0) a = 16'($urandom);
            else if ($urandom_range(0, 3) == 0) a = stream[s] + (stream[s] - m_prev) * 0 + 16'd2;
            else a = stream[s] + 16'($urandom_range(0, 15)) - 16'd8;
            stream[s] = a;
            enc_send(a, "sweep R2 R3 R4 R5 R6 R7");
        end

        done = 1;
        finish_run();
    end

endmodule